// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block sits between a bank of interrupt event sources and a processor core. Each source raises a flag bit, and software supplies an enable bit and a three-bit priority for each one. The block registers every flag on the system clock. On the following cycle it picks the best pending source among those that are both flagged and enabled. It then compares that source's priority with the level at which the processor is currently running.

A request is offered only when the winner's level is strictly above the processor level. The request bit, the vector number and the level are written into a holding register, which drives the outputs. Each source's vector number is fixed and equals a base value plus its index. While the processor holds acknowledge high, the holding register is frozen, so the vector and level it reads cannot shift under it. Once acknowledge drops, the register follows the live evaluation again from the next edge.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A flag value on `flag_i` just before clock edge k is sampled at edge k and reflected at the outputs after edge k+1, so a flag held for one cycle yields a request for exactly one cycle, two edges later (when acknowledge is low).
- R2: A source takes part in arbitration only when its flag bit and its bit in `enable_i` are both 1.
- R3: A source whose priority field is 0 never produces a request, and `irq_o` high always comes with a nonzero `lvl_o`.
- R4: Among pending sources with different priorities, the one with the highest 3-bit priority value wins.
- R5: Among pending sources tied at the highest priority, the lowest source index wins, and `vec_o` equals `VEC_BASE` plus the winning index (index 4 with base 8 gives 12).
- R6: `irq_o` is raised only when the winner's level is strictly greater than `cpu_ipl_i`. An equal level gives no request.
- R7: `lvl_o` is the winner's priority zero-extended to 4 bits. When `irq_o` is 0, `vec_o` and `lvl_o` are both 0.
- R8: During any cycle in which `ack_i` is 1 at a clock edge, `irq_o`, `vec_o` and `lvl_o` keep their values across that edge.
- R9: At the first edge where `ack_i` is 0 again, the holding register takes the current evaluation.
- R10: Synchronous active-high reset clears the sampled flags and drives `irq_o`, `vec_o` and `lvl_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_i | input | N_SRC | Raw interrupt event flags, one per source |
| enable_i | input | N_SRC | Per-source enable mask |
| prio_i | input | N_SRC*3 | Per-source priority, source i at bits [3i+2:3i] |
| cpu_ipl_i | input | 4 | Current processor priority level |
| ack_i | input | 1 | Processor acknowledge; freezes the held request |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 7 | Vector number of the held request |
| lvl_o | output | 4 | Priority level of the held request |

## Verification
Two functions can fall in the same cycle: the acknowledge freeze, and a change in the live evaluation, such as a newly flagged source with a higher level or a drop in the processor level. The bench raises a better source while acknowledge is high and checks that the outputs stay put. It then releases acknowledge on the very cycle the new evaluation becomes ready and checks that the next edge takes the new winner. Both directed and random phases are judged every clock against a behavioural model that sorts the pending sources by level and index.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int PRIO_W = 3;
    localparam int LVL_W  = 4;
    localparam int VEC_W  = 7;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // candidate travelling up the selection tree
    typedef struct packed {
        logic  valid;
        prio_t prio;
        vec_t  idx;
    } cand_t;

    // content of the holding register
    typedef struct packed {
        logic req;
        vec_t vec;
        lvl_t lvl;
    } hold_t;

    // lower-index operand wins on equal priority
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        if (lo.valid && (!hi.valid || lo.prio >= hi.prio))
            return lo;
        return hi;
    endfunction

    function automatic lvl_t to_lvl(input prio_t p);
        return lvl_t'(p);
    endfunction

endpackage

// File: rtl/irq_flag_sampler.sv
module irq_flag_sampler #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] flag_i,
    output logic [N_SRC-1:0] flag_q
);
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_i;
    end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output cand_t                   win_o
);
    localparam int LG    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int NP    = 1 << LG;
    localparam int NODES = 2 * NP - 1;

    cand_t node [NODES];

    for (genvar i = 0; i < NP; i++) begin : g_leaf
        if (i < N_SRC) begin : g_real
            prio_t p;
            assign p = prio_i[i*PRIO_W +: PRIO_W];
            assign node[NP-1+i] = '{valid: pend_i[i] && (p != '0),
                                    prio:  p,
                                    idx:   vec_t'(i)};
        end else begin : g_pad
            assign node[NP-1+i] = '0;
        end
    end

    for (genvar j = 0; j < NP - 1; j++) begin : g_merge
        assign node[j] = pick(node[2*j+1], node[2*j+2]);
    end

    assign win_o = node[0];
endmodule

// File: rtl/irq_hold_reg.sv
module irq_hold_reg
    import irq_arb_pkg::*;
#(
    parameter int VEC_BASE = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ack_i,
    input  lvl_t  cpu_ipl_i,
    input  cand_t win_i,
    output hold_t hold_o
);
    hold_t hold_q;
    hold_t hold_d;
    logic  above;

    assign above = win_i.valid && (to_lvl(win_i.prio) > cpu_ipl_i);

    always_comb begin
        hold_d = '0;
        if (above) begin
            hold_d.req = 1'b1;
            hold_d.vec = vec_t'(VEC_BASE) + win_i.idx;
            hold_d.lvl = to_lvl(win_i.prio);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         hold_q <= '0;
        else if (!ack_i) hold_q <= hold_d;
    end

    assign hold_o = hold_q;

    // R8: acknowledge freezes the held content
    a_r8_ack_freeze: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> $stable(hold_q));

    // R6: a captured request is strictly above the level seen at capture
    a_r6_strictly_above: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> (!hold_q.req || hold_q.lvl > $past(cpu_ipl_i)));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC    = 16,
    parameter int VEC_BASE = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        flag_i,
    input  logic [N_SRC-1:0]        enable_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [LVL_W-1:0]        cpu_ipl_i,
    input  logic                    ack_i,
    output logic                    irq_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic [LVL_W-1:0]        lvl_o
);
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] pend;
    cand_t            win;
    hold_t            hold;

    irq_flag_sampler #(.N_SRC(N_SRC)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .flag_i (flag_i),
        .flag_q (flag_q)
    );

    assign pend = flag_q & enable_i;

    irq_prio_tree #(.N_SRC(N_SRC)) u_tree (
        .pend_i (pend),
        .prio_i (prio_i),
        .win_o  (win)
    );

    irq_hold_reg #(.VEC_BASE(VEC_BASE)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ack_i     (ack_i),
        .cpu_ipl_i (cpu_ipl_i),
        .win_i     (win),
        .hold_o    (hold)
    );

    assign irq_o = hold.req;
    assign vec_o = hold.vec;
    assign lvl_o = hold.lvl;

    // R2: the tree only names a winner when some source is flagged and enabled
    a_r2_win_needs_pending: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (|(flag_q & enable_i)));

    // R3: a request never carries level zero
    a_r3_nonzero_level: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (lvl_o != '0));

    // R7: idle outputs are zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (vec_o == '0 && lvl_o == '0));
endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 16;
    localparam int BASE = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   flag_i = '0;
    logic [N-1:0]   enable_i = '0;
    logic [N*3-1:0] prio_i = '0;
    logic [3:0]     cpu_ipl_i = '0;
    logic           ack_i = 1'b0;
    logic           irq_o;
    logic [6:0]     vec_o;
    logic [3:0]     lvl_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R10";

    // behavioural model state
    bit m_flag [N];
    bit m_irq;
    int m_vec;
    int m_lvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arbiter #(.N_SRC(N), .VEC_BASE(BASE)) u_irq_prio_arbiter (
        .clk(clk), .rst(rst), .flag_i(flag_i), .enable_i(enable_i),
        .prio_i(prio_i), .cpu_ipl_i(cpu_ipl_i), .ack_i(ack_i),
        .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) m_flag[i] = 0;
            m_irq = 0; m_vec = 0; m_lvl = 0;
        end else begin
            if (!ack_i) begin
                int best; int bp;
                best = -1; bp = 0;
                for (int i = 0; i < N; i++) begin
                    int p;
                    p = int'(prio_i[i*3 +: 3]);
                    if (m_flag[i] && enable_i[i] && p > 0 && (best < 0 || p > bp)) begin
                        best = i; bp = p;
                    end
                end
                if (best >= 0 && bp > int'(cpu_ipl_i)) begin
                    m_irq = 1; m_vec = BASE + best; m_lvl = bp;
                end else begin
                    m_irq = 0; m_vec = 0; m_lvl = 0;
                end
            end
            for (int i = 0; i < N; i++) m_flag[i] = flag_i[i];
        end
    end

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (irq_o !== m_irq || int'(vec_o) != m_vec || int'(lvl_o) != m_lvl) begin
                fails++;
                $display("FAIL %s model: got irq=%0b vec=%0d lvl=%0d exp irq=%0b vec=%0d lvl=%0d",
                         tag, irq_o, vec_o, lvl_o, m_irq, m_vec, m_lvl);
            end
        end
    end

    task automatic expect_out(input string req, input bit e_irq, input int e_vec, input int e_lvl);
        checks++;
        if (irq_o !== e_irq || int'(vec_o) != e_vec || int'(lvl_o) != e_lvl) begin
            fails++;
            $display("FAIL %s: got irq=%0b vec=%0d lvl=%0d exp irq=%0b vec=%0d lvl=%0d",
                     req, irq_o, vec_o, lvl_o, e_irq, e_vec, e_lvl);
        end
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_prio(input int idx, input int p);
        prio_i[idx*3 +: 3] = 3'(p);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        steps(3);
        expect_out("R10", 0, 0, 0);
        rst = 1'b0;
        enable_i = '1;

        // R1 and R4: single source, two-edge latency
        tag = "R1";
        set_prio(3, 5);
        flag_i = N'(1) << 3;
        steps(1);
        expect_out("R1", 0, 0, 0);
        steps(1);
        expect_out("R1", 1, 11, 5);
        flag_i = '0;
        steps(2);
        expect_out("R7", 0, 0, 0);

        // R1: one-cycle pulse gives one-cycle request
        flag_i = N'(1) << 3;
        steps(1);
        flag_i = '0;
        steps(1);
        expect_out("R1", 1, 11, 5);
        steps(1);
        expect_out("R1", 0, 0, 0);

        // R2: disabled source ignored
        tag = "R2";
        set_prio(6, 7);
        enable_i[6] = 1'b0;
        flag_i = N'(1) << 6;
        steps(3);
        expect_out("R2", 0, 0, 0);
        enable_i[6] = 1'b1;
        steps(1);
        expect_out("R2", 1, 14, 7);
        flag_i = '0;

        // R3: priority zero never requests
        tag = "R3";
        set_prio(7, 0);
        flag_i = N'(1) << 7;
        steps(3);
        expect_out("R3", 0, 0, 0);

        // R4: higher priority wins
        tag = "R4";
        set_prio(2, 3);
        set_prio(9, 6);
        flag_i = (N'(1) << 2) | (N'(1) << 9);
        steps(2);
        expect_out("R4", 1, 17, 6);

        // R5: tie goes to lowest index
        tag = "R5";
        set_prio(4, 4);
        set_prio(12, 4);
        flag_i = (N'(1) << 4) | (N'(1) << 12);
        steps(2);
        expect_out("R5", 1, 12, 4);

        // R6: strict comparison with processor level
        tag = "R6";
        flag_i = N'(1) << 1;
        set_prio(1, 4);
        cpu_ipl_i = 4'd4;
        steps(3);
        expect_out("R6", 0, 0, 0);
        cpu_ipl_i = 4'd3;
        steps(1);
        expect_out("R6", 1, 9, 4);
        cpu_ipl_i = 4'd8;
        steps(1);
        expect_out("R6", 0, 0, 0);
        cpu_ipl_i = 4'd0;
        steps(1);
        expect_out("R7", 1, 9, 4);

        // R8: freeze while acknowledged, better source arrives
        tag = "R8";
        ack_i = 1'b1;
        set_prio(0, 7);
        flag_i = (N'(1) << 1) | (N'(1) << 0);
        steps(4);
        expect_out("R8", 1, 9, 4);
        cpu_ipl_i = 4'd7;
        flag_i = '0;
        steps(2);
        expect_out("R8", 1, 9, 4);

        // R9: release on the cycle a new evaluation is ready
        tag = "R9";
        cpu_ipl_i = 4'd2;
        flag_i = N'(1) << 9;
        steps(1);
        ack_i = 1'b0;
        steps(1);
        expect_out("R9", 1, 17, 6);

        // random phase
        tag = "R8";
        flag_i = '0;
        for (int c = 0; c < 3000; c++) begin
            flag_i    = N'($urandom);
            enable_i  = N'($urandom) | N'($urandom);
            prio_i    = {$urandom, $urandom};
            cpu_ipl_i = 4'($urandom_range(0, 8));
            ack_i     = ($urandom_range(0, 3) == 0);
            steps(1);
        end
        ack_i = 1'b0;
        steps(2);
        finish_run();
    end
endmodule